// File: doc/BRIEF.md
# Serial Clock Pulse-Pattern Reset Detector

This block sits beside the serial slave port of a mixed-signal device and lets a host reset that port using nothing but the serial clock line. While chip select is held low, it passes the serial clock through a synchronizer into a free-running oscillator domain. There it times every high and every low phase of the line in oscillator cycles. A reset is recognised when the host sends three high pulses in a row whose widths fall into three separate, growing windows, with a short low gap between them.

When the third pulse ends with a valid width, the detector emits a one-cycle reset request for the rest of the interface. It then enters a hold-off of sixteen oscillator cycles during which the serial clock is ignored. A pulse of the wrong width, a gap that is too short, or chip select going high abandons a partial pattern. A 3-bit state output exposes the pattern tracker for debug.

States: `IDLE` waits for a rising edge; `HIGH1`, `HIGH2` and `HIGH3` time the first, second and third high pulse; `LOW1` and `LOW2` time the gaps; `HOLD` is the post-reset hold-off. Transitions: IDLE→HIGH1 on a rise. HIGH1→LOW1 on a fall with width in window 1, otherwise →IDLE. LOWn→next HIGH on a rise after a gap of at least 5 cycles, otherwise →IDLE. HIGH2→LOW2 and HIGH3→HOLD on a fall inside their own window. On a miss they go →LOW1 if the width fits window 1, otherwise →IDLE. HOLD→IDLE after 16 cycles. Chip select high forces →IDLE from any state except HOLD.

Top module: `sclk_rst_detect`

## Requirements
- R1: After reset `reset_pulse` is 0 and `dbg_state` reads the IDLE code; state codes are IDLE=0, HIGH1=1, LOW1=2, HIGH2=3, LOW2=4, HIGH3=5, HOLD=6.
- R2: A first high pulse is accepted only when its width is from 300 to 500 oscillator cycles, both ends included.
- R3: A low gap after an accepted high pulse must last at least 5 cycles. A shorter gap returns the tracker to IDLE, and the high pulse that ends that gap is not taken as a first pulse.
- R4: A second high pulse is accepted only for widths from 550 to 750 cycles inclusive.
- R5: A third high pulse of 1050 to 1250 cycles inclusive gives exactly one `reset_pulse` cycle. It is high in the third clock cycle after `sclk_in` is first sampled low, and in that cycle `dbg_state` shows HOLD.
- R6: A second or third high pulse outside its own window returns the tracker to IDLE. If its width fits the first window, the tracker goes to LOW1 instead, and that pulse acts as a fresh first pulse.
- R7: Width counting saturates above 1250, so a high pulse of any length (for example 2448 cycles) beyond a window is never accepted.
- R8: `cs_n` high at a clock edge puts the tracker in IDLE from any state except HOLD, and no reset request follows from the aborted pattern.
- R9: After a reset request the tracker stays in HOLD for 16 cycles whatever `sclk_in` does, then returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk_in | input | 1 | Serial clock line, asynchronous to `clk` |
| reset_pulse | output | 1 | One-cycle reset request to the serial interface |
| dbg_state | output | 3 | Current tracker state code |

## Verification
A level change on `sclk_in` reaches the edge detector after two synchronizer flops. The tracker state and `reset_pulse` move at the next edge. So both outputs reflect a change three rising edges after `sclk_in` is first sampled at its new level. A change on `cs_n` shows up one edge later. The bench drives inputs on falling edges and advances a behavioural model on every rising edge using plain integers for run length and hold count. It compares both outputs against that model on every falling edge. Directed checks at the exact cycles derived above confirm pulse timing, HOLD duration and pulse counts per scenario.

// File: rtl/sclk_rst_pkg.sv
package sclk_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HIGH1 = 3'd1,
        ST_LOW1  = 3'd2,
        ST_HIGH2 = 3'd3,
        ST_LOW2  = 3'd4,
        ST_HIGH3 = 3'd5,
        ST_HOLD  = 3'd6
    } det_state_t;

endpackage

// File: rtl/sclk_sync_edge.sv
module sclk_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              level_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~level_q;
    assign fall  = ~level & level_q;

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W   = 11,
    parameter int SAT_VAL = 1251
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    output logic [CNT_W-1:0] width
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            width <= SAT;
        else if (edge_seen)    width <= ONE;
        else if (width < SAT)  width <= width + ONE;
    end

endmodule

// File: rtl/sclk_rst_detect.sv
module sclk_rst_detect
    import sclk_rst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int W1_MIN      = 300,
    parameter int W1_MAX      = 500,
    parameter int W2_MIN      = 550,
    parameter int W2_MAX      = 750,
    parameter int W3_MIN      = 1050,
    parameter int W3_MAX      = 1250,
    parameter int LOW_MIN     = 5,
    parameter int HOLD_CYC    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_in,
    output logic       reset_pulse,
    output logic [2:0] dbg_state
);

    localparam int MAX_12  = (W1_MAX > W2_MAX) ? W1_MAX : W2_MAX;
    localparam int MAX_ALL = (MAX_12 > W3_MAX) ? MAX_12 : W3_MAX;
    localparam int SAT_VAL = MAX_ALL + 1;
    localparam int CNT_W   = $clog2(SAT_VAL + 1);
    localparam int HOLD_W  = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic             s_level;
    logic             s_rise;
    logic             s_fall;
    logic [CNT_W-1:0] phase_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic             hold_done;
    logic             win1, win2, win3, gap_ok;
    logic             fire;
    det_state_t       state, state_nxt;

    sclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sclk_in),
        .level (s_level),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    phase_timer #(.CNT_W(CNT_W), .SAT_VAL(SAT_VAL)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (s_rise | s_fall),
        .width     (phase_cnt)
    );

    assign win1      = (phase_cnt >= CNT_W'(W1_MIN)) && (phase_cnt <= CNT_W'(W1_MAX));
    assign win2      = (phase_cnt >= CNT_W'(W2_MIN)) && (phase_cnt <= CNT_W'(W2_MAX));
    assign win3      = (phase_cnt >= CNT_W'(W3_MIN)) && (phase_cnt <= CNT_W'(W3_MAX));
    assign gap_ok    = (phase_cnt >= CNT_W'(LOW_MIN));
    assign hold_done = (hold_cnt == HOLD_W'(HOLD_CYC - 1));

    // Next-state and request decision
    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        unique case (state)
            ST_IDLE:  if (s_rise) state_nxt = ST_HIGH1;
            ST_HIGH1: if (s_fall) state_nxt = win1 ? ST_LOW1 : ST_IDLE;
            ST_LOW1:  if (s_rise) state_nxt = gap_ok ? ST_HIGH2 : ST_IDLE;
            ST_HIGH2: if (s_fall) state_nxt = win2 ? ST_LOW2 : (win1 ? ST_LOW1 : ST_IDLE);
            ST_LOW2:  if (s_rise) state_nxt = gap_ok ? ST_HIGH3 : ST_IDLE;
            ST_HIGH3: begin
                if (s_fall) begin
                    if (win3) begin
                        state_nxt = ST_HOLD;
                        fire      = 1'b1;
                    end else begin
                        state_nxt = win1 ? ST_LOW1 : ST_IDLE;
                    end
                end
            end
            ST_HOLD:  if (hold_done) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
        if (cs_n && (state != ST_HOLD)) begin
            state_nxt = ST_IDLE;
            fire      = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Outputs and hold-off timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reset_pulse <= 1'b0;
            hold_cnt    <= '0;
        end else begin
            reset_pulse <= fire;
            if (state == ST_HOLD) hold_cnt <= hold_cnt + HOLD_W'(1);
            else                  hold_cnt <= '0;
        end
    end

    assign dbg_state = state;

endmodule

// File: rtl/sclk_rst_check.sv
module sclk_rst_check
    import sclk_rst_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int SAT_VAL = 1251
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             reset_pulse,
    input logic [2:0]       dbg_state,
    input logic [CNT_W-1:0] phase_cnt
);

    // R5: request appears together with entry into hold-off
    assert_pulse_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (dbg_state == ST_HOLD));

    // R5: request lasts one cycle
    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    // R9: hold-off is only entered through a request
    assert_hold_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dbg_state == ST_HOLD) && ($past(dbg_state) != ST_HOLD)) |-> reset_pulse);

    // R8: chip select high clears the tracker outside hold-off
    assert_cs_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && (dbg_state != ST_HOLD)) |=> (dbg_state == ST_IDLE));

    // R7: saturated counter either stays saturated or restarts on an edge
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt == CNT_W'(SAT_VAL)) |=> ((phase_cnt == CNT_W'(SAT_VAL)) || (phase_cnt == CNT_W'(1))));

    // R1: only defined state codes appear
    assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_state <= 3'd6);

endmodule

bind sclk_rst_detect sclk_rst_check u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .reset_pulse (reset_pulse),
    .dbg_state   (dbg_state),
    .phase_cnt   (phase_cnt)
);

// File: tb/test_sclk_rst_detect.sv
module test_sclk_rst_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk_in = 1'b0;
    logic       reset_pulse;
    logic [2:0] dbg_state;

    int vectors = 0;
    int miscompares = 0;
    int pulses = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    sclk_rst_detect i_sclk_rst_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk_in     (sclk_in),
        .reset_pulse (reset_pulse),
        .dbg_state   (dbg_state)
    );

    // Behavioural reference model
    localparam int M_IDLE = 0, M_H1 = 1, M_L1 = 2, M_H2 = 3, M_L2 = 4, M_H3 = 5, M_HOLD = 6;
    bit     q0, q1, q2;
    integer run_len;
    integer m_state;
    integer m_hold;
    bit     m_pulse;

    function automatic bit in_rng(integer v, integer lo, integer hi);
        return (v >= lo) && (v <= hi);
    endfunction

    always @(posedge clk) begin
        bit     up, dn, req;
        integer nx;
        if (!rst_n) begin
            q0 = 0; q1 = 0; q2 = 0;
            run_len = 100000; m_state = M_IDLE; m_hold = 0; m_pulse = 0;
        end else begin
            up  = q1 && !q2;
            dn  = !q1 && q2;
            req = 0;
            nx  = m_state;
            case (m_state)
                M_IDLE: if (up) nx = M_H1;
                M_H1:   if (dn) nx = in_rng(run_len, 300, 500) ? M_L1 : M_IDLE;
                M_L1:   if (up) nx = (run_len >= 5) ? M_H2 : M_IDLE;
                M_H2:   if (dn) nx = in_rng(run_len, 550, 750) ? M_L2 :
                                     (in_rng(run_len, 300, 500) ? M_L1 : M_IDLE);
                M_L2:   if (up) nx = (run_len >= 5) ? M_H3 : M_IDLE;
                M_H3:   if (dn) begin
                            if (in_rng(run_len, 1050, 1250)) begin nx = M_HOLD; req = 1; end
                            else nx = in_rng(run_len, 300, 500) ? M_L1 : M_IDLE;
                        end
                M_HOLD: if (m_hold == 15) nx = M_IDLE;
                default: nx = M_IDLE;
            endcase
            if (cs_n && m_state != M_HOLD) begin nx = M_IDLE; req = 0; end
            m_hold  = (m_state == M_HOLD) ? m_hold + 1 : 0;
            run_len = (up || dn) ? 1 : run_len + 1;
            q2 = q1; q1 = q0; q0 = sclk_in;
            m_state = nx;
            m_pulse = req;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (reset_pulse) pulses++;
        if (rst_n) begin
            vectors += 2;
            if (reset_pulse !== m_pulse) begin
                miscompares++;
                $display("FAIL %s reset_pulse actual %0b expected %0b at cycle %0d",
                         cur_req, reset_pulse, m_pulse, cycles);
            end
            if (dbg_state !== 3'(m_state)) begin
                miscompares++;
                $display("FAIL %s dbg_state actual %0d expected %0d at cycle %0d",
                         cur_req, dbg_state, m_state, cycles);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles >= 150000) begin
            miscompares++;
            $display("FAIL watchdog actual %0d cycles expected fewer than 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check_val(string tag, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hi(int n);
        sclk_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic lo(int n);
        sclk_in = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_case(string tag, output int base);
        cur_req = tag;
        cs_n = 1'b1;
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        base = pulses;
    endtask

    task automatic end_case(string tag, int base, int exp);
        lo(40);
        check_val({tag, " pulse count"}, pulses - base, exp);
        check_val({tag, " back in IDLE"}, dbg_state, 0);
    endtask

    task automatic pattern(int a, int g1, int b, int g2, int c);
        hi(a); lo(g1); hi(b); lo(g2); hi(c);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check_val("R1 reset pulse low", reset_pulse, 0);
        check_val("R1 reset state IDLE", dbg_state, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4/R5: lower bounds of every window with minimum gaps
        start_case("R5", base);
        pattern(300, 5, 550, 5, 1050);
        end_case("R5 min bounds", base, 1);

        // R2/R4/R5: upper bounds, with exact pulse timing and hold length (R9)
        start_case("R9", base);
        pattern(500, 5, 750, 5, 1250);
        lo(2);
        check_val("R5 no pulse two cycles after fall", reset_pulse, 0);
        lo(1);
        check_val("R5 pulse in third cycle", reset_pulse, 1);
        check_val("R5 state HOLD with pulse", dbg_state, 6);
        for (int i = 0; i < 15; i++) begin
            sclk_in = ~sclk_in;
            @(negedge clk);
        end
        check_val("R9 still HOLD despite toggling", dbg_state, 6);
        sclk_in = 1'b0;
        @(negedge clk);
        check_val("R9 IDLE after 16 hold cycles", dbg_state, 0);
        end_case("R9 max bounds", base, 1);

        // R2: first pulse just outside its window
        start_case("R2", base);
        pattern(299, 5, 600, 5, 1100);
        end_case("R2 first 299", base, 0);
        start_case("R2", base);
        pattern(501, 5, 600, 5, 1100);
        end_case("R2 first 501", base, 0);

        // R3: short gap aborts and the next pulse is not a first pulse
        start_case("R3", base);
        hi(400); lo(4); hi(600);
        lo(3);
        check_val("R3 abort to IDLE", dbg_state, 0);
        lo(5); hi(1100);
        end_case("R3 gap 4", base, 0);

        // R4: second pulse out of window and not a first-window fit
        start_case("R4", base);
        pattern(400, 5, 549, 5, 1100);
        end_case("R4 second 549", base, 0);
        start_case("R4", base);
        pattern(400, 5, 751, 5, 1100);
        end_case("R4 second 751", base, 0);

        // R5: third pulse just outside its window
        start_case("R5", base);
        pattern(400, 5, 600, 5, 1049);
        end_case("R5 third 1049", base, 0);
        start_case("R5", base);
        pattern(400, 5, 600, 5, 1251);
        end_case("R5 third 1251", base, 0);

        // R6: misplaced first-window pulse restarts the pattern
        start_case("R6", base);
        hi(400); lo(5); hi(450); lo(3);
        check_val("R6 restart in LOW1", dbg_state, 2);
        lo(3); hi(600); lo(6); hi(1100);
        end_case("R6 restart then complete", base, 1);

        // R7: very long first pulse is not accepted through wrap-around
        start_case("R7", base);
        pattern(2448, 5, 600, 5, 1100);
        end_case("R7 long first", base, 0);

        // R8: chip select high mid-pattern clears the tracker
        start_case("R8", base);
        hi(400); lo(5); hi(600); lo(8);
        cs_n = 1'b1;
        @(negedge clk);
        check_val("R8 cleared by chip select", dbg_state, 0);
        cs_n = 1'b0;
        lo(5); hi(1100);
        end_case("R8 aborted pattern", base, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule